// File: doc/BRIEF.md
# Serial Flash Command Decoder

This block is the device-side front end of a serial NOR flash memory on a four-wire serial bus. The four wires are an active-low select, a serial clock, data in and data out. It runs on a local system clock and oversamples the bus wires. Each transaction begins with a one-byte opcode, which is looked up in a fixed table. The table says whether address bytes, a dummy byte, incoming data or outgoing data follow.

After the opcode, the block gathers a three-byte start address. For read-type commands it streams bytes out from a simple combinational read port, a live status byte, a lock byte or a built-in identification value. For programming commands it hands each received data byte to a page buffer through a one-cycle strobe.

Commands that change the memory are committed only when the select line rises. The select must rise after a whole number of bytes, and the command must have all its fields. The block then raises a one-cycle execute pulse that carries the opcode, the start address and the data byte count. While the array is busy, every command except the status read is ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, spi_miso_o, spi_miso_oe_o, pgm_valid_o and exec_valid_o are all 0.
- R2: Opcode, address and data bits are taken most significant bit first, one per rising serial clock edge after select falls. The opcodes are: 06h, 04h, C7h, B9h, ABh (no fields); D8h, DBh (3 address bytes); 02h, 0Ah, E5h (3 address bytes then data in); 03h, E8h (3 address bytes then data out); 0Bh (3 address bytes, one dummy byte, data out); 05h and 9Fh (data out right away).
- R3: Opcode 03h returns the byte on rd_data_i for rd_addr_o, which holds the received address. The address rises by one, wrapping at 24 bits, after each full output byte, with no limit until select rises. Output bits change on falling clock edges, MSB first. The first bit appears on the falling edge that follows the last address bit.
- R4: Opcode 0Bh skips one dummy byte after the address and then behaves as in R3.
- R5: Opcode 05h repeats status_i for as long as select stays low. Each output bit is taken from the current value of status_i.
- R6: Opcode 9Fh returns the ID_VALUE parameter, most significant byte first, for three bytes. Opcode E8h returns lock_i once after its address. Beyond these limits, spi_miso_oe_o and spi_miso_o are 0.
- R7: For opcodes 02h and 0Ah, each full data byte after the address gives one pgm_valid_o pulse with the byte on pgm_data_o, for at most PAGE_BYTES bytes. For E5h, only the first data byte is forwarded.
- R8: One clock after select rise is seen, exec_valid_o pulses for one cycle. It carries the opcode, the received start address and the count of forwarded data bytes. This happens only when the command is complete: 06h, 04h, C7h, B9h and ABh after the opcode; D8h and DBh after all three address bytes; 02h, 0Ah and E5h after at least one data byte.
- R9: No execute pulse is raised if the number of rising clock edges since select fell is not a multiple of 8 when select rises.
- R10: Opcodes 03h, 0Bh, 05h, 9Fh and E8h never raise an execute pulse. Select may rise in the middle of any output bit, and the next transaction decodes normally.
- R11: An opcode not listed in R2 gives no output enable, no data strobe and no execute pulse until select rises.
- R12: If busy_i is high when an opcode byte completes, every opcode other than 05h is handled as in R11. 05h still streams status.
- R13: spi_miso_oe_o is high only during a data-out phase, and spi_miso_o is 0 whenever spi_miso_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n_i | input | 1 | Active-low select |
| spi_sck_i | input | 1 | Serial clock |
| spi_mosi_i | input | 1 | Serial data into the device |
| spi_miso_o | output | 1 | Serial data out of the device |
| spi_miso_oe_o | output | 1 | Output enable for spi_miso_o |
| busy_i | input | 1 | Array write, program or erase in progress |
| status_i | input | 8 | Live status byte for 05h |
| lock_i | input | 8 | Lock byte for E8h |
| rd_addr_o | output | ADDR_W | Array read address |
| rd_data_i | input | 8 | Array byte at rd_addr_o |
| pgm_valid_o | output | 1 | One-cycle strobe for a program data byte |
| pgm_data_o | output | 8 | Program data byte |
| exec_valid_o | output | 1 | One-cycle execute pulse |
| exec_op_o | output | 8 | Opcode to execute |
| exec_addr_o | output | ADDR_W | Start address to execute |
| exec_count_o | output | CNT_W | Number of forwarded data bytes |

## Verification
A wrong phase or bit counter shows at the ports within one byte time. Output bytes come out shifted or from the wrong source, or the output enable rises in the wrong bit. A boundary check that is off by one shows one clock after select rises, as a missing or extra execute pulse. A count that does not saturate shows as a 257th data strobe, or as a wrong count on the execute pulse.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDID  = 8'h9F;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRLK  = 8'hE5;
  localparam logic [7:0] OP_RDLK  = 8'hE8;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_PWR   = 8'h0A;
  localparam logic [7:0] OP_PPRG  = 8'h02;
  localparam logic [7:0] OP_PERS  = 8'hDB;
  localparam logic [7:0] OP_SERS  = 8'hD8;
  localparam logic [7:0] OP_BERS  = 8'hC7;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_DIN, PH_DOUT, PH_TAIL, PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {
    SRC_ARRAY, SRC_STATUS, SRC_IDENT, SRC_LOCK
  } src_e;

  typedef struct packed {
    logic       known;
    logic       has_addr;
    logic       has_dummy;
    logic       has_din;
    logic       has_dout;
    logic       needs_edge;
    src_e       src;
    logic [1:0] dout_max;   // 0 = unlimited
    logic       din_one;
  } cmd_info_t;

endpackage

// File: rtl/sfd_rst_sync.sv
module sfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns_o = chain_q[STAGES-1];

endmodule

// File: rtl/sfd_sync.sv
module sfd_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sfd_decode.sv
module sfd_decode
  import sfd_pkg::*;
(
  input  logic [7:0] op_i,
  output cmd_info_t  info_o
);

  always_comb begin
    info_o     = '0;
    info_o.src = SRC_ARRAY;
    case (op_i)
      OP_WREN, OP_WRDI, OP_BERS, OP_SLEEP, OP_WAKE: begin
        info_o.known      = 1'b1;
        info_o.needs_edge = 1'b1;
      end
      OP_RDID: begin
        info_o.known    = 1'b1;
        info_o.has_dout = 1'b1;
        info_o.src      = SRC_IDENT;
        info_o.dout_max = 2'd3;
      end
      OP_RDSR: begin
        info_o.known    = 1'b1;
        info_o.has_dout = 1'b1;
        info_o.src      = SRC_STATUS;
      end
      OP_WRLK: begin
        info_o.known      = 1'b1;
        info_o.has_addr   = 1'b1;
        info_o.has_din    = 1'b1;
        info_o.din_one    = 1'b1;
        info_o.needs_edge = 1'b1;
      end
      OP_RDLK: begin
        info_o.known    = 1'b1;
        info_o.has_addr = 1'b1;
        info_o.has_dout = 1'b1;
        info_o.src      = SRC_LOCK;
        info_o.dout_max = 2'd1;
      end
      OP_READ: begin
        info_o.known    = 1'b1;
        info_o.has_addr = 1'b1;
        info_o.has_dout = 1'b1;
      end
      OP_FREAD: begin
        info_o.known     = 1'b1;
        info_o.has_addr  = 1'b1;
        info_o.has_dummy = 1'b1;
        info_o.has_dout  = 1'b1;
      end
      OP_PWR, OP_PPRG: begin
        info_o.known      = 1'b1;
        info_o.has_addr   = 1'b1;
        info_o.has_din    = 1'b1;
        info_o.needs_edge = 1'b1;
      end
      OP_PERS, OP_SERS: begin
        info_o.known      = 1'b1;
        info_o.has_addr   = 1'b1;
        info_o.needs_edge = 1'b1;
      end
      default: info_o = info_o;
    endcase
  end

endmodule

// File: rtl/sfd_tx.sv
module sfd_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic       shift_i,
  input  logic [7:0] byte_i,
  input  logic [1:0] lim_i,
  output logic       miso_o,
  output logic       oe_o,
  output logic       byte_done_o,
  output logic [1:0] byte_cnt_o
);

  logic [2:0] obit_q, obit_d;
  logic [1:0] bcnt_q, bcnt_d;
  logic       miso_q, miso_d;
  logic       oe_q, oe_d;
  logic       done_q, done_d;
  logic       in_lim;

  assign in_lim = (lim_i == 2'd0) || (bcnt_q < lim_i);

  always_comb begin
    obit_d = obit_q;
    bcnt_d = bcnt_q;
    miso_d = miso_q;
    oe_d   = oe_q;
    done_d = 1'b0;
    if (!active_i) begin
      obit_d = '0;
      bcnt_d = '0;
      miso_d = 1'b0;
      oe_d   = 1'b0;
    end else if (shift_i) begin
      miso_d = in_lim ? byte_i[~obit_q] : 1'b0;
      oe_d   = in_lim;
      obit_d = obit_q + 3'd1;
      if (obit_q == 3'd7) begin
        done_d = 1'b1;
        if (bcnt_q != 2'd3) bcnt_d = bcnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obit_q <= '0;
      bcnt_q <= '0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      obit_q <= obit_d;
      bcnt_q <= bcnt_d;
      miso_q <= miso_d;
      oe_q   <= oe_d;
      done_q <= done_d;
    end
  end

  AST_TX_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && shift_i && lim_i != 2'd0 && bcnt_q >= lim_i) |=> !oe_q); // R6

  assign miso_o      = miso_q;
  assign oe_o        = oe_q;
  assign byte_done_o = done_q;
  assign byte_cnt_o  = bcnt_q;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import sfd_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          PAGE_BYTES  = 256,
  parameter int          SYNC_STAGES = 2,
  parameter logic [23:0] ID_VALUE    = 24'hA1B2C3,
  parameter int          CNT_W       = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n_i,
  input  logic              spi_sck_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        lock_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              pgm_valid_o,
  output logic [7:0]        pgm_data_o,
  output logic              exec_valid_o,
  output logic [7:0]        exec_op_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  output logic [CNT_W-1:0]  exec_count_o
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [AB_W-1:0]  AB_LAST  = AB_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] PAGE_LIM = CNT_W'(PAGE_BYTES);

  // reset and bus sampling
  logic       rst_ns;
  logic [2:0] bus_s;
  logic       cs_s, sck_s, mosi_s;
  logic       sck_d_q, cs_d_q;
  logic       sck_rise, sck_fall, cs_rise;

  sfd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns_o(rst_ns)
  );

  sfd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_ns),
    .d_i({spi_mosi_i, spi_sck_i, spi_cs_n_i}), .q_o(bus_s)
  );

  assign cs_s   = bus_s[0];
  assign sck_s  = bus_s[1];
  assign mosi_s = bus_s[2];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
    end else begin
      sck_d_q <= sck_s;
      cs_d_q  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign cs_rise  = cs_s & ~cs_d_q;

  // command state
  phase_e             phase_q, phase_d;
  logic [2:0]         bitc_q, bitc_d;
  logic [6:0]         sh_q, sh_d;
  logic [7:0]         op_q, op_d;
  cmd_info_t          info_q, info_d, info_in;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [AB_W-1:0]    abyte_q, abyte_d;
  logic [CNT_W-1:0]   dcnt_q, dcnt_d;
  logic               pgm_v_q, pgm_v_d;
  logic [7:0]         pgm_b_q, pgm_b_d;
  logic               ex_v_q, ex_v_d;
  logic [7:0]         ex_op_q, ex_op_d;
  logic [ADDR_W-1:0]  ex_a_q, ex_a_d;
  logic [CNT_W-1:0]   ex_c_q, ex_c_d;

  logic [7:0]         byte_in;
  logic               accept;
  logic               edge_ok;
  logic [CNT_W-1:0]   din_lim;
  logic               tx_done;
  logic [1:0]         tx_bcnt;
  logic [7:0]         out_byte;

  assign byte_in = {sh_q, mosi_s};

  sfd_decode u_dec (.op_i(byte_in), .info_o(info_in));

  assign accept  = info_in.known && (!busy_i || byte_in == OP_RDSR);
  assign din_lim = info_q.din_one ? CNT_W'(1) : PAGE_LIM;
  assign edge_ok = (bitc_q == 3'd0) && info_q.known && info_q.needs_edge &&
                   ((phase_q == PH_TAIL) ||
                    (phase_q == PH_DIN && dcnt_q != '0));

  always_comb begin
    phase_d = phase_q;
    bitc_d  = bitc_q;
    sh_d    = sh_q;
    op_d    = op_q;
    info_d  = info_q;
    addr_d  = addr_q;
    abyte_d = abyte_q;
    dcnt_d  = dcnt_q;
    pgm_v_d = 1'b0;
    pgm_b_d = pgm_b_q;
    ex_v_d  = 1'b0;
    ex_op_d = ex_op_q;
    ex_a_d  = ex_a_q;
    ex_c_d  = ex_c_q;

    if (cs_rise && edge_ok) begin
      ex_v_d  = 1'b1;
      ex_op_d = op_q;
      ex_a_d  = addr_q;
      ex_c_d  = dcnt_q;
    end

    if (cs_s) begin
      phase_d = PH_OPC;
      bitc_d  = '0;
      abyte_d = '0;
      dcnt_d  = '0;
    end else begin
      if (sck_rise) begin
        sh_d   = byte_in[6:0];
        bitc_d = bitc_q + 3'd1;
        if (bitc_q == 3'd7) begin
          case (phase_q)
            PH_OPC: begin
              op_d   = byte_in;
              info_d = info_in;
              if (!accept)               phase_d = PH_SKIP;
              else if (info_in.has_addr) phase_d = PH_ADDR;
              else if (info_in.has_dout) phase_d = PH_DOUT;
              else                       phase_d = PH_TAIL;
            end
            PH_ADDR: begin
              addr_d  = {addr_q[ADDR_W-9:0], byte_in};
              abyte_d = abyte_q + 1'b1;
              if (abyte_q == AB_LAST) begin
                if (info_q.has_dummy)     phase_d = PH_DUMMY;
                else if (info_q.has_dout) phase_d = PH_DOUT;
                else if (info_q.has_din)  phase_d = PH_DIN;
                else                      phase_d = PH_TAIL;
              end
            end
            PH_DUMMY: phase_d = PH_DOUT;
            PH_DIN: begin
              if (dcnt_q < din_lim) begin
                pgm_v_d = 1'b1;
                pgm_b_d = byte_in;
                dcnt_d  = dcnt_q + 1'b1;
              end
            end
            default: phase_d = phase_q;
          endcase
        end
      end
      if (tx_done && info_q.src == SRC_ARRAY && info_q.has_addr) begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q <= PH_OPC;
      bitc_q  <= '0;
      sh_q    <= '0;
      op_q    <= '0;
      info_q  <= '0;
      addr_q  <= '0;
      abyte_q <= '0;
      dcnt_q  <= '0;
      pgm_v_q <= 1'b0;
      pgm_b_q <= '0;
      ex_v_q  <= 1'b0;
      ex_op_q <= '0;
      ex_a_q  <= '0;
      ex_c_q  <= '0;
    end else begin
      phase_q <= phase_d;
      bitc_q  <= bitc_d;
      sh_q    <= sh_d;
      op_q    <= op_d;
      info_q  <= info_d;
      addr_q  <= addr_d;
      abyte_q <= abyte_d;
      dcnt_q  <= dcnt_d;
      pgm_v_q <= pgm_v_d;
      pgm_b_q <= pgm_b_d;
      ex_v_q  <= ex_v_d;
      ex_op_q <= ex_op_d;
      ex_a_q  <= ex_a_d;
      ex_c_q  <= ex_c_d;
    end
  end

  // output source selection
  always_comb begin
    case (info_q.src)
      SRC_STATUS: out_byte = status_i;
      SRC_LOCK:   out_byte = lock_i;
      SRC_IDENT: begin
        case (tx_bcnt)
          2'd0:    out_byte = ID_VALUE[23:16];
          2'd1:    out_byte = ID_VALUE[15:8];
          default: out_byte = ID_VALUE[7:0];
        endcase
      end
      default:    out_byte = rd_data_i;
    endcase
  end

  sfd_tx u_tx (
    .clk(clk), .rst_n(rst_ns),
    .active_i(!cs_s),
    .shift_i(sck_fall && phase_q == PH_DOUT),
    .byte_i(out_byte),
    .lim_i(info_q.dout_max),
    .miso_o(spi_miso_o),
    .oe_o(spi_miso_oe_o),
    .byte_done_o(tx_done),
    .byte_cnt_o(tx_bcnt)
  );

  assign rd_addr_o    = addr_q;
  assign pgm_valid_o  = pgm_v_q;
  assign pgm_data_o   = pgm_b_q;
  assign exec_valid_o = ex_v_q;
  assign exec_op_o    = ex_op_q;
  assign exec_addr_o  = ex_a_q;
  assign exec_count_o = ex_c_q;

  AST_EXEC_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_ns)
    exec_valid_o |-> $past(bitc_q == 3'd0)); // R9

  AST_EXEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ns)
    exec_valid_o |=> !exec_valid_o); // R8

  AST_OE_IN_DOUT: assert property (@(posedge clk) disable iff (!rst_ns)
    spi_miso_oe_o |-> $past(phase_q == PH_DOUT)); // R13

  AST_PGM_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_ns)
    pgm_valid_o |-> (dcnt_q != '0 && dcnt_q <= PAGE_LIM)); // R7

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_ns)
    (!cs_s && sck_rise && bitc_q == 3'd7 && phase_q == PH_OPC &&
     busy_i && byte_in != OP_RDSR) |=> (phase_q == PH_SKIP || cs_s)); // R12

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [23:0] IDV = 24'hA1B2C3;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sck, mosi, busy;
  logic [7:0]  status, lock;
  logic        miso, oe;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data;
  logic        pgm_valid;
  logic [7:0]  pgm_data;
  logic        exec_valid;
  logic [7:0]  exec_op;
  logic [23:0] exec_addr;
  logic [8:0]  exec_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.ID_VALUE(IDV)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .spi_cs_n_i(cs_n), .spi_sck_i(sck),
    .spi_mosi_i(mosi), .spi_miso_o(miso), .spi_miso_oe_o(oe),
    .busy_i(busy), .status_i(status), .lock_i(lock),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .pgm_valid_o(pgm_valid), .pgm_data_o(pgm_data),
    .exec_valid_o(exec_valid), .exec_op_o(exec_op),
    .exec_addr_o(exec_addr), .exec_count_o(exec_count)
  );

  function automatic logic [7:0] mem_of(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction
  assign rd_data = mem_of(rd_addr);

  typedef struct {
    logic [7:0]  op;
    logic [23:0] addr;
    bit          chk_addr;
    int          cnt;
  } exp_exec_t;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_exec_t  exp_exec[$];
  logic [7:0] exp_pgm[$];
  logic [7:0] txq[$];
  logic       rxb[$];
  logic       rxoe[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_exec(input logic [7:0] op, input logic [23:0] a,
                           input bit ca, input int c);
    exp_exec_t e;
    e.op = op; e.addr = a; e.chk_addr = ca; e.cnt = c;
    exp_exec.push_back(e);
  endtask

  task automatic run(input int nbits);
    rxb.delete();
    rxoe.delete();
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      int bi;
      bi = i / 8;
      mosi = (bi < txq.size()) ? txq[bi][7 - (i % 8)] : 1'b0;
      repeat (HALF) @(negedge clk);
      rxb.push_back(miso);
      rxoe.push_back(oe);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  function automatic logic [7:0] rx_byte(input int start);
    logic [7:0] r = '0;
    for (int k = 0; k < 8; k++) r = {r[6:0], rxb[start + k]};
    return r;
  endfunction

  function automatic bit oe_is(input int start, input int n, input bit v);
    for (int k = start; k < start + n; k++) if (rxoe[k] != v) return 1'b0;
    return 1'b1;
  endfunction

  task automatic drained(input string req);
    check(exp_exec.size() == 0, req, "pending execute pulses", exp_exec.size(), 0);
    check(exp_pgm.size() == 0, req, "pending data strobes", exp_pgm.size(), 0);
  endtask

  // per-clock comparison against the expected event queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (exec_valid) begin
        if (exp_exec.size() == 0) begin
          check(1'b0, "R9", "unexpected execute op", exec_op, 0);
        end else begin
          exp_exec_t e;
          e = exp_exec.pop_front();
          check(exec_op == e.op, "R8", "execute opcode", exec_op, e.op);
          if (e.chk_addr) check(exec_addr == e.addr, "R8", "execute address", exec_addr, e.addr);
          check(int'(exec_count) == e.cnt, "R8", "execute count", exec_count, e.cnt);
        end
      end
      if (pgm_valid) begin
        if (exp_pgm.size() == 0) begin
          check(1'b0, "R7", "unexpected data strobe", pgm_data, 0);
        end else begin
          logic [7:0] b;
          b = exp_pgm.pop_front();
          check(pgm_data == b, "R7", "strobed data byte", pgm_data, b);
        end
      end
      if (!oe && miso) check(1'b0, "R13", "data out high while disabled", 1, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    busy = 1'b0; status = 8'h00; lock = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check(miso == 1'b0, "R1", "miso after reset", miso, 0);
    check(oe == 1'b0, "R1", "oe after reset", oe, 0);
    check(pgm_valid == 1'b0, "R1", "pgm strobe after reset", pgm_valid, 0);
    check(exec_valid == 1'b0, "R1", "exec after reset", exec_valid, 0);

    // R8 write enable on a byte boundary
    txq = '{8'h06};
    push_exec(8'h06, 24'h0, 1'b0, 0);
    run(8);
    drained("R8");

    // R9 select rises after 7 and after 9 clocks
    txq = '{8'h06};
    run(7);
    drained("R9");
    txq = '{8'h04};
    run(9);
    drained("R9");

    // R2 R3 read with address increment across a page edge
    txq = '{8'h03, 8'h00, 8'h12, 8'hFE};
    run(32 + 24);
    check(oe_is(0, 32, 1'b0), "R13", "oe low during command bytes", 0, 0);
    check(oe_is(32, 24, 1'b1), "R3", "oe high during read data", 0, 1);
    check(rx_byte(32) == mem_of(24'h0012FE), "R2", "read byte 0", rx_byte(32), mem_of(24'h0012FE));
    check(rx_byte(40) == mem_of(24'h0012FF), "R3", "read byte 1", rx_byte(40), mem_of(24'h0012FF));
    check(rx_byte(48) == mem_of(24'h001300), "R3", "read byte 2", rx_byte(48), mem_of(24'h001300));
    drained("R10");

    // R4 fast read with dummy byte and address wrap
    txq = '{8'h0B, 8'hFF, 8'hFF, 8'hFE, 8'h00};
    run(40 + 24);
    check(oe_is(32, 8, 1'b0), "R4", "oe low during dummy byte", 0, 0);
    check(rx_byte(40) == mem_of(24'hFFFFFE), "R4", "fast byte 0", rx_byte(40), mem_of(24'hFFFFFE));
    check(rx_byte(48) == mem_of(24'hFFFFFF), "R4", "fast byte 1", rx_byte(48), mem_of(24'hFFFFFF));
    check(rx_byte(56) == mem_of(24'h000000), "R4", "fast byte wrap", rx_byte(56), mem_of(24'h000000));
    drained("R10");

    // R5 status streaming
    status = 8'h81;
    txq = '{8'h05};
    run(8 + 16);
    check(rx_byte(8) == 8'h81, "R5", "status byte 0", rx_byte(8), 8'h81);
    check(rx_byte(16) == 8'h81, "R5", "status byte 1", rx_byte(16), 8'h81);
    status = 8'h42;
    run(8 + 8);
    check(rx_byte(8) == 8'h42, "R5", "status after change", rx_byte(8), 8'h42);

    // R6 identification, limited to three bytes
    txq = '{8'h9F};
    run(8 + 32);
    check(rx_byte(8) == IDV[23:16], "R6", "id byte 0", rx_byte(8), IDV[23:16]);
    check(rx_byte(16) == IDV[15:8], "R6", "id byte 1", rx_byte(16), IDV[15:8]);
    check(rx_byte(24) == IDV[7:0], "R6", "id byte 2", rx_byte(24), IDV[7:0]);
    check(oe_is(32, 8, 1'b0) && rx_byte(32) == 8'h00, "R6", "id past limit", rx_byte(32), 0);

    // R6 lock read, one byte
    lock = 8'h5A;
    txq = '{8'hE8, 8'h00, 8'h00, 8'h10};
    run(32 + 16);
    check(rx_byte(32) == 8'h5A, "R6", "lock byte", rx_byte(32), 8'h5A);
    check(oe_is(40, 8, 1'b0), "R6", "oe after lock byte", 1, 0);
    drained("R10");

    // R7 R8 page program with three bytes
    txq = '{8'h02, 8'h00, 8'h01, 8'h00, 8'h11, 8'h22, 8'h33};
    exp_pgm = '{8'h11, 8'h22, 8'h33};
    push_exec(8'h02, 24'h000100, 1'b1, 3);
    run(56);
    drained("R7");

    // R9 page program ending mid-byte
    exp_pgm = '{8'h11, 8'h22, 8'h33};
    run(56 + 4);
    drained("R9");

    // R8 page erase complete, sector erase with a short address
    txq = '{8'hDB, 8'h0A, 8'h0B, 8'h0C};
    push_exec(8'hDB, 24'h0A0B0C, 1'b1, 0);
    run(32);
    drained("R8");
    txq = '{8'hD8, 8'h01, 8'h02};
    run(24);
    drained("R8");

    // R7 write lock forwards only the first data byte
    txq = '{8'hE5, 8'h00, 8'h00, 8'h00, 8'h77, 8'h88};
    exp_pgm = '{8'h77};
    push_exec(8'hE5, 24'h000000, 1'b1, 1);
    run(48);
    drained("R7");

    // R7 page write longer than a page
    txq = '{8'h0A, 8'h00, 8'h02, 8'h00};
    for (int n = 0; n < 258; n++) begin
      txq.push_back(8'(n * 7 + 3));
      if (n < 256) exp_pgm.push_back(8'(n * 7 + 3));
    end
    push_exec(8'h0A, 24'h000200, 1'b1, 256);
    run(8 * 262);
    drained("R7");

    // R10 read aborted mid-bit, then a normal command
    txq = '{8'h03, 8'h00, 8'h00, 8'h40};
    run(32 + 5);
    drained("R10");
    txq = '{8'h04};
    push_exec(8'h04, 24'h0, 1'b0, 0);
    run(8);
    drained("R10");

    // R11 unknown opcode
    txq = '{8'h5F, 8'h11, 8'h22, 8'h33};
    run(32);
    check(oe_is(0, 32, 1'b0), "R11", "oe after unknown opcode", 1, 0);
    drained("R11");

    // R12 busy: array access and writes ignored, status still served
    busy = 1'b1;
    txq = '{8'h03, 8'h00, 8'h00, 8'h00};
    run(48);
    check(oe_is(0, 48, 1'b0), "R12", "oe for read while busy", 1, 0);
    txq = '{8'h02, 8'h00, 8'h00, 8'h00, 8'h99};
    run(40);
    drained("R12");
    txq = '{8'hC7};
    run(8);
    drained("R12");
    status = 8'h01;
    txq = '{8'h05};
    run(8 + 16);
    check(rx_byte(8) == 8'h01 && rx_byte(16) == 8'h01, "R12", "status while busy", rx_byte(16), 8'h01);
    busy = 1'b0;
    txq = '{8'hC7};
    push_exec(8'hC7, 24'h0, 1'b0, 0);
    run(8);
    drained("R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule